// File: doc/BRIEF.md
# Multicycle Processor Sequencer

This block is the control unit of a small multicycle load/store processor. It steps each instruction through a fixed series of states: fetch, decode, and then one, two or three execute states, depending on the instruction. In each state it drives the enables and select lines for a datapath that it does not contain. These lines cover program-counter write, instruction-register write, register-file write (to the instruction's destination or to the link register), data-memory write, memory address source, ALU operand and operation selects, writeback result source and flag write. One ALU serves every stage. In fetch it increments the program counter. In execute it computes results, memory addresses and branch targets.

The datapath presents the instruction's class, function and condition fields, taken from the instruction register, together with the stored N, Z, C, V flags (bits 3..0 of `flags_i`). The sequencer samples the fields and flags only in the decode state and latches what it decides. From then until the next fetch, later changes on those inputs have no effect. The control outputs depend only on registered state, so they are stable for the whole cycle.

Top module: `mcyc_ctrl`

## Requirements
- R1: While reset is active and after it is released, the state code is 0 (fetch) and the outputs show the fetch pattern given in R2.
- R2: State codes are fetch=0, decode=1, exec1=2, exec2=3, exec3=4. In fetch the block raises pc_we and ir_we, with addr_sel=0 (program counter), alu_a_sel=0 (program counter), alu_b_sel=0 (constant four), alu_op=0 (add) and res_sel=0 (ALU), and the next state is decode. In decode every write enable is low.
- R3: Class 00 with function 0..5 (add, sub, and, orr, lsl, lsr) drives alu_op equal to the function code in exec1, with alu_a_sel=1 (register), alu_b_sel=1 (register), res_sel=0, rf_we=1 and flag_we=1. The next state is fetch.
- R4: Class 00 with function 6 (compare) drives exec1 as in R3 but with alu_op=1 (subtract) and rf_we=0. The next state is fetch.
- R5: Class 01 with function 1 (load) goes through three execute states. In exec1 it drives alu_a_sel=1 and alu_b_sel=2 (immediate) with add and no write. In exec2 it drives addr_sel=1 (ALU result) and no write. In exec3 it drives rf_we=1 with res_sel=1 (memory data). It then returns to fetch.
- R6: Class 01 with function 0 (store) drives exec1 as in R5. In exec2 it drives addr_sel=1 and mem_we=1. It then returns to fetch.
- R7: Condition codes, evaluated for class 10 only: 0 requires Z set, 1 requires Z clear, 2 requires C set, 3 requires C clear, 4 requires N set, 5 requires N clear, 6 requires V set, 7 requires V clear, and 14 is always true. Every other code is never true.
- R8: A taken class 10 function 0 (branch) drives pc_we=1 in exec1 with alu_a_sel=0, alu_b_sel=2, add and res_sel=0. The next state is fetch.
- R9: A taken class 10 function 1 (branch with link) drives rf_we=1, rf_link=1 and res_sel=2 (program counter) in exec1. In exec2 it drives the branch pattern of R8. It then returns to fetch.
- R10: A taken class 10 function 2 (register-indirect branch) drives pc_we=1 with res_sel=3 (register operand) in exec1. The next state is fetch.
- R11: A class 10 function 0..2 whose condition is false spends one exec1 cycle with every write enable low, then returns to fetch.
- R12: Class 11, class 00 function 7..15, class 01 function 2..15 and class 10 function 3..15 are illegal. These go from decode straight back to fetch with no write enable raised.
- R13: Changes on the field and flag inputs after the decode state have no effect on the remaining states of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cls_i | input | 2 | Instruction class field |
| fn_i | input | 4 | Function field |
| cond_i | input | 4 | Condition field |
| flags_i | input | 4 | Stored flags N, Z, C, V (bits 3..0) |
| state_o | output | 3 | Current state code |
| pc_we_o | output | 1 | Program counter write |
| ir_we_o | output | 1 | Instruction register write |
| rf_we_o | output | 1 | Register file write |
| rf_link_o | output | 1 | Register write goes to the link register |
| mem_we_o | output | 1 | Data memory write |
| addr_sel_o | output | 1 | Memory address: 0 program counter, 1 ALU result |
| alu_a_sel_o | output | 1 | ALU A: 0 program counter, 1 register |
| alu_b_sel_o | output | 2 | ALU B: 0 four, 1 register, 2 immediate |
| alu_op_o | output | 3 | ALU operation code |
| res_sel_o | output | 2 | Result: 0 ALU, 1 memory, 2 program counter, 3 register |
| flag_we_o | output | 1 | Flag register write |

## Verification
The bench builds the block with its package defaults: a 2-bit class, 4-bit function and condition fields, and 4 flags. These widths are small enough to sweep every class, function and condition combination under several flag patterns. A behavioural model in the bench predicts the full output vector for each cycle of each instruction and compares it on every clock. After each decode the bench drives random values on the fields and flags, which tests the sampling rule in the same runs.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
    localparam int CLS_W = 2;
    localparam int FN_W  = 4;
    localparam int CC_W  = 4;
    localparam int FLG_W = 4;
    localparam int ST_W  = 3;
    localparam int OP_W  = 3;
    localparam int SEL_W = 2;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    localparam logic [CLS_W-1:0] CLS_DP  = 2'd0;
    localparam logic [CLS_W-1:0] CLS_MEM = 2'd1;
    localparam logic [CLS_W-1:0] CLS_BR  = 2'd2;

    localparam logic [FN_W-1:0] FN_CMP = 4'd6;
    localparam logic [FN_W-1:0] FN_STR = 4'd0;
    localparam logic [FN_W-1:0] FN_LDR = 4'd1;
    localparam logic [FN_W-1:0] FN_B   = 4'd0;
    localparam logic [FN_W-1:0] FN_BL  = 4'd1;
    localparam logic [FN_W-1:0] FN_BX  = 4'd2;

    localparam logic [CC_W-1:0] CC_ZS = 4'd0;
    localparam logic [CC_W-1:0] CC_ZC = 4'd1;
    localparam logic [CC_W-1:0] CC_CS = 4'd2;
    localparam logic [CC_W-1:0] CC_CC = 4'd3;
    localparam logic [CC_W-1:0] CC_NS = 4'd4;
    localparam logic [CC_W-1:0] CC_NC = 4'd5;
    localparam logic [CC_W-1:0] CC_VS = 4'd6;
    localparam logic [CC_W-1:0] CC_VC = 4'd7;
    localparam logic [CC_W-1:0] CC_AL = 4'd14;

    localparam logic [OP_W-1:0] OP_ADD = 3'd0;
    localparam logic [OP_W-1:0] OP_SUB = 3'd1;

    localparam logic       A_PC     = 1'b0;
    localparam logic       A_REG    = 1'b1;
    localparam logic [1:0] B_FOUR   = 2'd0;
    localparam logic [1:0] B_REG    = 2'd1;
    localparam logic [1:0] B_IMM    = 2'd2;
    localparam logic [1:0] RES_ALU  = 2'd0;
    localparam logic [1:0] RES_MEM  = 2'd1;
    localparam logic [1:0] RES_PC   = 2'd2;
    localparam logic [1:0] RES_REG  = 2'd3;
    localparam logic       ADDR_PC  = 1'b0;
    localparam logic       ADDR_ALU = 1'b1;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EX1    = 3'd2,
        ST_EX2    = 3'd3,
        ST_EX3    = 3'd4
    } state_e;

    typedef enum logic [3:0] {
        K_ALU, K_CMP, K_LDR, K_STR, K_BR, K_BRL, K_BRX, K_SKIP, K_ILL
    } kind_e;

    typedef struct packed {
        logic             pc_we;
        logic             ir_we;
        logic             rf_we;
        logic             rf_link;
        logic             mem_we;
        logic             addr_sel;
        logic             a_sel;
        logic [SEL_W-1:0] b_sel;
        logic [OP_W-1:0]  alu_op;
        logic [SEL_W-1:0] res_sel;
        logic             flag_we;
    } ctrl_t;

    typedef struct packed {
        state_e          st;
        kind_e           kind;
        logic [OP_W-1:0] op;
    } seq_t;
endpackage

// File: rtl/mcyc_cond.sv
module mcyc_cond
    import mcyc_pkg::*;
(
    input  logic [CC_W-1:0]  cond_i,
    input  logic [FLG_W-1:0] flags_i,
    output logic             pass_o
);
    always_comb begin
        case (cond_i)
            CC_ZS:   pass_o = flags_i[FLG_Z];
            CC_ZC:   pass_o = !flags_i[FLG_Z];
            CC_CS:   pass_o = flags_i[FLG_C];
            CC_CC:   pass_o = !flags_i[FLG_C];
            CC_NS:   pass_o = flags_i[FLG_N];
            CC_NC:   pass_o = !flags_i[FLG_N];
            CC_VS:   pass_o = flags_i[FLG_V];
            CC_VC:   pass_o = !flags_i[FLG_V];
            CC_AL:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
    import mcyc_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    input  logic [FN_W-1:0]  fn_i,
    input  logic [CC_W-1:0]  cond_i,
    input  logic [FLG_W-1:0] flags_i,
    output kind_e            kind_o,
    output logic [OP_W-1:0]  op_o
);
    logic pass;

    mcyc_cond u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_i),
        .pass_o  (pass)
    );

    always_comb begin
        kind_o = K_ILL;
        op_o   = OP_ADD;
        case (cls_i)
            CLS_DP: begin
                if (fn_i == FN_CMP) begin
                    kind_o = K_CMP;
                    op_o   = OP_SUB;
                end else if (fn_i < FN_CMP) begin
                    kind_o = K_ALU;
                    op_o   = fn_i[OP_W-1:0];
                end
            end
            CLS_MEM: begin
                if (fn_i == FN_LDR)      kind_o = K_LDR;
                else if (fn_i == FN_STR) kind_o = K_STR;
            end
            CLS_BR: begin
                if (fn_i == FN_B)       kind_o = pass ? K_BR  : K_SKIP;
                else if (fn_i == FN_BL) kind_o = pass ? K_BRL : K_SKIP;
                else if (fn_i == FN_BX) kind_o = pass ? K_BRX : K_SKIP;
            end
            default: kind_o = K_ILL;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl_out.sv
module mcyc_ctrl_out
    import mcyc_pkg::*;
(
    input  state_e          st_i,
    input  kind_e           kind_i,
    input  logic [OP_W-1:0] op_i,
    output ctrl_t           ctrl_o
);
    always_comb begin
        ctrl_o          = '0;
        ctrl_o.a_sel    = A_PC;
        ctrl_o.b_sel    = B_FOUR;
        ctrl_o.alu_op   = OP_ADD;
        ctrl_o.res_sel  = RES_ALU;
        ctrl_o.addr_sel = ADDR_PC;
        case (st_i)
            ST_FETCH: begin
                ctrl_o.ir_we = 1'b1;
                ctrl_o.pc_we = 1'b1;
            end
            ST_EX1: begin
                case (kind_i)
                    K_ALU, K_CMP: begin
                        ctrl_o.a_sel   = A_REG;
                        ctrl_o.b_sel   = B_REG;
                        ctrl_o.alu_op  = op_i;
                        ctrl_o.flag_we = 1'b1;
                        ctrl_o.rf_we   = (kind_i == K_ALU);
                    end
                    K_LDR, K_STR: begin
                        ctrl_o.a_sel = A_REG;
                        ctrl_o.b_sel = B_IMM;
                    end
                    K_BR: begin
                        ctrl_o.b_sel = B_IMM;
                        ctrl_o.pc_we = 1'b1;
                    end
                    K_BRL: begin
                        ctrl_o.rf_we   = 1'b1;
                        ctrl_o.rf_link = 1'b1;
                        ctrl_o.res_sel = RES_PC;
                    end
                    K_BRX: begin
                        ctrl_o.pc_we   = 1'b1;
                        ctrl_o.res_sel = RES_REG;
                    end
                    default: ;
                endcase
            end
            ST_EX2: begin
                case (kind_i)
                    K_LDR: ctrl_o.addr_sel = ADDR_ALU;
                    K_STR: begin
                        ctrl_o.addr_sel = ADDR_ALU;
                        ctrl_o.mem_we   = 1'b1;
                    end
                    K_BRL: begin
                        ctrl_o.b_sel = B_IMM;
                        ctrl_o.pc_we = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_EX3: begin
                if (kind_i == K_LDR) begin
                    ctrl_o.rf_we   = 1'b1;
                    ctrl_o.res_sel = RES_MEM;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [FN_W-1:0]  fn_i,
    input  logic [CC_W-1:0]  cond_i,
    input  logic [FLG_W-1:0] flags_i,
    output logic [ST_W-1:0]  state_o,
    output logic             pc_we_o,
    output logic             ir_we_o,
    output logic             rf_we_o,
    output logic             rf_link_o,
    output logic             mem_we_o,
    output logic             addr_sel_o,
    output logic             alu_a_sel_o,
    output logic [SEL_W-1:0] alu_b_sel_o,
    output logic [OP_W-1:0]  alu_op_o,
    output logic [SEL_W-1:0] res_sel_o,
    output logic             flag_we_o
);
    seq_t            seq_d, seq_q;
    kind_e           dec_kind;
    logic [OP_W-1:0] dec_op;
    ctrl_t           ctrl;

    mcyc_decode u_decode (
        .cls_i   (cls_i),
        .fn_i    (fn_i),
        .cond_i  (cond_i),
        .flags_i (flags_i),
        .kind_o  (dec_kind),
        .op_o    (dec_op)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_FETCH: seq_d.st = ST_DECODE;
            ST_DECODE: begin
                seq_d.kind = dec_kind;
                seq_d.op   = dec_op;
                seq_d.st   = (dec_kind == K_ILL) ? ST_FETCH : ST_EX1;
            end
            ST_EX1: begin
                if (seq_q.kind == K_LDR || seq_q.kind == K_STR || seq_q.kind == K_BRL)
                    seq_d.st = ST_EX2;
                else
                    seq_d.st = ST_FETCH;
            end
            ST_EX2:  seq_d.st = (seq_q.kind == K_LDR) ? ST_EX3 : ST_FETCH;
            default: seq_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_FETCH;
            seq_q.kind <= K_ILL;
            seq_q.op   <= OP_ADD;
        end else begin
            seq_q <= seq_d;
        end
    end

    mcyc_ctrl_out u_out (
        .st_i   (seq_q.st),
        .kind_i (seq_q.kind),
        .op_i   (seq_q.op),
        .ctrl_o (ctrl)
    );

    assign state_o     = seq_q.st;
    assign pc_we_o     = ctrl.pc_we;
    assign ir_we_o     = ctrl.ir_we;
    assign rf_we_o     = ctrl.rf_we;
    assign rf_link_o   = ctrl.rf_link;
    assign mem_we_o    = ctrl.mem_we;
    assign addr_sel_o  = ctrl.addr_sel;
    assign alu_a_sel_o = ctrl.a_sel;
    assign alu_b_sel_o = ctrl.b_sel;
    assign alu_op_o    = ctrl.alu_op;
    assign res_sel_o   = ctrl.res_sel;
    assign flag_we_o   = ctrl.flag_we;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cls_i,
    input logic [3:0] fn_i,
    input logic [3:0] cond_i,
    input logic       z_i,
    input logic [2:0] state_o,
    input logic       pc_we_o,
    input logic       ir_we_o,
    input logic       rf_we_o,
    input logic       rf_link_o,
    input logic       mem_we_o,
    input logic       addr_sel_o,
    input logic [1:0] res_sel_o,
    input logic       flag_we_o
);
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4); // R1
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd0 |=> state_o == 3'd1); // R2
    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd1 |-> !(pc_we_o || ir_we_o || rf_we_o || mem_we_o || flag_we_o)); // R2
    AST_IR_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we_o |-> state_o == 3'd0); // R2
    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 |-> rf_we_o && res_sel_o == 2'd1); // R5
    AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 |=> state_o == 3'd0); // R5
    AST_STORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> state_o == 3'd3 && addr_sel_o); // R6
    AST_NE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd1 && cls_i == 2'd2 && fn_i == 4'd0 && cond_i == 4'd1 && z_i
        |=> !pc_we_o); // R11
    AST_LINK_THEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_link_o |=> state_o == 3'd3 && pc_we_o); // R9
    AST_ILLEGAL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd1 && cls_i == 2'd3 |=> state_o == 3'd0); // R12
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cls_i      (cls_i),
    .fn_i       (fn_i),
    .cond_i     (cond_i),
    .z_i        (flags_i[2]),
    .state_o    (state_o),
    .pc_we_o    (pc_we_o),
    .ir_we_o    (ir_we_o),
    .rf_we_o    (rf_we_o),
    .rf_link_o  (rf_link_o),
    .mem_we_o   (mem_we_o),
    .addr_sel_o (addr_sel_o),
    .res_sel_o  (res_sel_o),
    .flag_we_o  (flag_we_o)
);

// File: tb/tb_mcyc_ctrl.sv
module tb_mcyc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cls = '0;
    logic [3:0] fn = '0, cond = '0, flags = '0;
    logic [2:0] state;
    logic       pc_we, ir_we, rf_we, rf_link, mem_we, addr_sel, a_sel, flag_we;
    logic [1:0] b_sel, res_sel;
    logic [2:0] alu_op;

    int n_chk = 0;
    int n_err = 0;
    logic [17:0] exp_q[$];
    string tag;

    always #4 clk = ~clk;

    mcyc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cls_i(cls), .fn_i(fn), .cond_i(cond), .flags_i(flags),
        .state_o(state), .pc_we_o(pc_we), .ir_we_o(ir_we), .rf_we_o(rf_we),
        .rf_link_o(rf_link), .mem_we_o(mem_we), .addr_sel_o(addr_sel),
        .alu_a_sel_o(a_sel), .alu_b_sel_o(b_sel), .alu_op_o(alu_op),
        .res_sel_o(res_sel), .flag_we_o(flag_we)
    );

    function automatic logic [17:0] mk(int st, int pw, int iw, int rw, int lk, int mw,
                                       int ad, int aa, int bb, int op, int rs, int fw);
        return {3'(st), 1'(pw), 1'(iw), 1'(rw), 1'(lk), 1'(mw), 1'(ad), 1'(aa),
                2'(bb), 3'(op), 2'(rs), 1'(fw)};
    endfunction

    function automatic logic [17:0] observed();
        return {state, pc_we, ir_we, rf_we, rf_link, mem_we, addr_sel, a_sel,
                b_sel, alu_op, res_sel, flag_we};
    endfunction

    task automatic check(input logic [17:0] got, input logic [17:0] exp, input string r);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", r, got, exp);
        end
    endtask

    function automatic bit cond_true(int cc, logic [3:0] f);
        case (cc)
            0: return f[2] == 1'b1;
            1: return f[2] == 1'b0;
            2: return f[1] == 1'b1;
            3: return f[1] == 1'b0;
            4: return f[3] == 1'b1;
            5: return f[3] == 1'b0;
            6: return f[0] == 1'b1;
            7: return f[0] == 1'b0;
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic plan(input int c, input int f, input int cc, input logic [3:0] fl);
        bit tk;
        exp_q.delete();
        exp_q.push_back(mk(0,1,1,0,0,0,0,0,0,0,0,0));
        exp_q.push_back(mk(1,0,0,0,0,0,0,0,0,0,0,0));
        tk = cond_true(cc, fl);
        if (c == 0 && f <= 6) begin
            tag = (f == 6) ? "R4 R13" : "R3 R13";
            exp_q.push_back(mk(2,0,0,(f != 6),0,0,0,1,1,(f == 6) ? 1 : f,0,1));
        end else if (c == 1 && f <= 1) begin
            exp_q.push_back(mk(2,0,0,0,0,0,0,1,2,0,0,0));
            if (f == 1) begin
                tag = "R5 R13";
                exp_q.push_back(mk(3,0,0,0,0,0,1,0,0,0,0,0));
                exp_q.push_back(mk(4,0,0,1,0,0,0,0,0,0,1,0));
            end else begin
                tag = "R6 R13";
                exp_q.push_back(mk(3,0,0,0,0,1,1,0,0,0,0,0));
            end
        end else if (c == 2 && f <= 2) begin
            if (!tk) begin
                tag = "R7 R11 R13";
                exp_q.push_back(mk(2,0,0,0,0,0,0,0,0,0,0,0));
            end else if (f == 0) begin
                tag = "R7 R8 R13";
                exp_q.push_back(mk(2,1,0,0,0,0,0,0,2,0,0,0));
            end else if (f == 1) begin
                tag = "R7 R9 R13";
                exp_q.push_back(mk(2,0,0,1,1,0,0,0,0,0,2,0));
                exp_q.push_back(mk(3,1,0,0,0,0,0,0,2,0,0,0));
            end else begin
                tag = "R7 R10 R13";
                exp_q.push_back(mk(2,1,0,0,0,0,0,0,0,0,3,0));
            end
        end else begin
            tag = "R12";
        end
    endtask

    task automatic run(input int c, input int f, input int cc, input logic [3:0] fl);
        logic [17:0] e;
        cls = 2'(c); fn = 4'(f); cond = 4'(cc); flags = fl;
        plan(c, f, cc, fl);
        while (exp_q.size() > 0) begin
            @(negedge clk);
            e = exp_q.pop_front();
            check(observed(), e, (e[17:15] <= 3'd1) ? {"R2 ", tag} : tag);
            if (e[17:15] == 3'd1) begin
                @(posedge clk);
                #1;
                cls = 2'($urandom); fn = 4'($urandom);
                cond = 4'($urandom); flags = 4'($urandom);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check(observed(), mk(0,1,1,0,0,0,0,0,0,0,0,0), "R1 reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int f = 0; f <= 6; f++) run(0, f, 0, 4'b0000);
        run(1, 1, 0, 4'b0000);
        run(1, 0, 0, 4'b0000);
        run(2, 0, 0, 4'b0100);
        run(2, 0, 0, 4'b0000);
        run(2, 0, 1, 4'b0100);
        run(2, 0, 2, 4'b0010);
        run(2, 0, 3, 4'b0010);
        run(2, 1, 14, 4'b0000);
        run(2, 2, 14, 4'b0000);
        run(2, 2, 9, 4'b1111);
        run(3, 0, 0, 4'b0000);
        run(0, 9, 0, 4'b0000);
        run(1, 5, 0, 4'b0000);
        run(2, 7, 14, 4'b0000);
        for (int c = 0; c < 4; c++)
            for (int f = 0; f < 16; f++)
                for (int cc = 0; cc < 16; cc++)
                    for (int p = 0; p < 4; p++)
                        if (c == 2 || (cc == 0 && p == 0))
                            run(c, f, cc, (p == 0) ? 4'b0100 : (p == 1) ? 4'b0010 :
                                          (p == 2) ? 4'b1000 : 4'b0001);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule